// File: doc/BRIEF.md
# Two-Strike Timer Watchdog

This block is a watchdog built on a down-counting general-purpose timer. Software programs the timer, enables the watchdog and services the timer interrupt through a small register port. The port has an address, a write strobe, write data and registered read data. A prescaler turns the system clock into a one-cycle tick every microsecond. The timer counter moves only on those ticks.

Each time the timer runs out it raises its interrupt. A single expiry is harmless. The watchdog acts only when the timer runs out a second time and the interrupt from the previous expiry is still unacknowledged. When that happens it drives a system reset pulse of fixed length. A software period of N seconds is therefore programmed as N*1,000,000/2 ticks, because two timer periods must pass with no service before the reset fires.

Three word-aligned registers are decoded. Offset 0x0 controls the timer. Offset 0x4 acknowledges and reports the interrupt. Offset 0x8 configures the watchdog and carries a sticky status bit for a second strike that did not reset.

Top module: `twin_strike_wdg`

## Requirements
- R1: After reset, irq_o and sys_rst_o are low, and reads of offsets 0x0, 0x4 and 0x8 return zero.
- R2: The counter decrements once every CLK_HZ/TICK_HZ clock cycles, with the prescaler phase restarted by any write to offset 0x0. With period P loaded by a write at clock edge W, the first expiry happens at edge W + P*CLK_HZ/TICK_HZ, and irq_o is high after it.
- R3: With the periodic flag (bit 30 of offset 0x0) set, the counter reloads the period on each expiry. Expiries repeat every P ticks.
- R4: With the periodic flag clear, the timer clears its own enable flag (bit 31 of offset 0x0) after one expiry and stops. The period field (bits 28:0) keeps its value.
- R5: Writing data with bit 30 set to offset 0x4 clears the pending interrupt. Writing data with bit 30 clear has no effect. Reading offset 0x4 returns the pending flag in bit 30, and irq_o equals that flag.
- R6: Offset 0x8 holds watchdog enable in bit 5, timer select in bit 4 (0 selects the timer) and reset enable in bit 2. With bits 5 and 2 set and bit 4 clear, an expiry while the interrupt is pending drives sys_rst_o high for exactly RST_CYCLES cycles, starting at that expiry edge.
- R7: If the interrupt is acknowledged between two expiries, no reset is generated.
- R8: If bit 2 of offset 0x8 is clear, a second strike leaves sys_rst_o low and sets a sticky status bit, read back in bit 8 of offset 0x8.
- R9: After firing once, the watchdog does not fire again until offset 0x8 is written. A write to offset 0x8 re-arms it and clears the sticky bit.
- R10: Writing zero to offset 0x0 stops the timer. Writing zero to offset 0x8 disables the watchdog.
- R11: With bit 4 of offset 0x8 set, no timer feeds the watchdog and no strike is taken.
- R12: Rewriting offset 0x0 while the timer runs restarts the count from the newly written period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after the address |
| irq_o | output | 1 | Timer interrupt, high while an expiry is unacknowledged |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The assertions assume that the write strobe lasts one cycle per access and that the address is stable while the strobe is high. They also assume CLK_HZ is at least twice TICK_HZ, so that two ticks are never adjacent. The stimulus drives every access at the falling edge for exactly one cycle. It programs only periods of several ticks. Every strike scenario is closed by stopping the timer and acknowledging the interrupt, so that no pending expiry carries over into the next case.

// File: rtl/strike_pkg.sv
package strike_pkg;
  localparam int DATA_W   = 32;
  localparam int PERIOD_W = 29;

  // register offsets
  localparam int OFS_TIMER = 'h0;
  localparam int OFS_ACK   = 'h4;
  localparam int OFS_GUARD = 'h8;

  // timer control bits
  localparam int TMR_EN_BIT  = 31;
  localparam int TMR_PER_BIT = 30;
  // interrupt acknowledge / pending bit
  localparam int ACK_BIT     = 30;
  // watchdog configuration bits
  localparam int G_EN_BIT     = 5;
  localparam int G_SEL_BIT    = 4;
  localparam int G_RSTEN_BIT  = 2;
  localparam int G_STICKY_BIT = 8;
endpackage

// File: rtl/strike_tick_gen.sv
module strike_tick_gen #(
  parameter int CLK_HZ  = 4_000_000,
  parameter int TICK_HZ = 1_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int DIV = (CLK_HZ / TICK_HZ < 1) ? 1 : CLK_HZ / TICK_HZ;
  localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (tick)      cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // R2: ticks are isolated single cycles when the divider exceeds one
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && DIV > 1) |=> !tick);
endmodule

// File: rtl/strike_timer.sv
module strike_timer #(
  parameter int PW = 29
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          ctrl_wr,
  input  logic          ctrl_en,
  input  logic          ctrl_per,
  input  logic [PW-1:0] ctrl_period,
  input  logic          ack,
  output logic          en_q,
  output logic          per_q,
  output logic [PW-1:0] period_q,
  output logic          expire,
  output logic          pending_q
);
  logic [PW-1:0] count_q;

  assign expire = en_q && tick && !ctrl_wr && (count_q <= PW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      per_q    <= 1'b0;
      period_q <= '0;
      count_q  <= '0;
    end else if (ctrl_wr) begin
      en_q     <= ctrl_en;
      per_q    <= ctrl_per;
      period_q <= ctrl_period;
      count_q  <= ctrl_period;
    end else if (en_q && tick) begin
      if (count_q <= PW'(1)) begin
        count_q <= period_q;
        if (!per_q) en_q <= 1'b0;
      end else begin
        count_q <= count_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         pending_q <= 1'b0;
    else if (expire) pending_q <= 1'b1;
    else if (ack)    pending_q <= 1'b0;
  end

  // R4: a one-shot expiry drops the enable flag
  p_oneshot_halts_r4: assert property (@(posedge clk) disable iff (rst)
    (expire && !per_q) |=> !en_q);
  // R5: an acknowledge without a fresh expiry clears the pending flag
  p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (ack && !expire) |=> !pending_q);
  // R2: the count holds between ticks unless software rewrites it
  p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ctrl_wr) |=> $stable(count_q));
endmodule

// File: rtl/strike_guard.sv
module strike_guard #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_wr,
  input  logic cfg_en,
  input  logic cfg_sel,
  input  logic cfg_rst_en,
  input  logic expire,
  input  logic pending,
  output logic en_q,
  output logic sel_q,
  output logic rst_en_q,
  output logic sticky_q,
  output logic sys_rst_q
);
  localparam int LW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES + 1) : 1;

  logic          fired_q;
  logic [LW-1:0] left_q;
  logic          strike;
  logic          fire;

  assign strike = expire && pending && en_q && !sel_q && !cfg_wr;
  assign fire   = strike && rst_en_q && !fired_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      sel_q    <= 1'b0;
      rst_en_q <= 1'b0;
      sticky_q <= 1'b0;
      fired_q  <= 1'b0;
    end else if (cfg_wr) begin
      en_q     <= cfg_en;
      sel_q    <= cfg_sel;
      rst_en_q <= cfg_rst_en;
      sticky_q <= 1'b0;
      fired_q  <= 1'b0;
    end else if (strike) begin
      if (!rst_en_q) sticky_q <= 1'b1;
      if (fire)      fired_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_rst_q <= 1'b0;
      left_q    <= '0;
    end else if (fire) begin
      sys_rst_q <= 1'b1;
      left_q    <= LW'(RST_CYCLES - 1);
    end else if (left_q != '0) begin
      left_q    <= left_q - 1'b1;
    end else begin
      sys_rst_q <= 1'b0;
    end
  end

  // R6: a reset pulse only begins on an expiry that found the interrupt pending
  p_rst_needs_pending_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_q) |-> $past(expire && pending));
  // R8 / R11: a reset pulse needs watchdog enable, reset enable and timer select 0
  p_rst_needs_enable_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_q) |-> $past(en_q && rst_en_q && !sel_q));
  // R9: once fired, no new pulse begins until a configuration write
  p_single_fire_r9: assert property (@(posedge clk) disable iff (rst)
    (fired_q && !cfg_wr) |=> !$rose(sys_rst_q));
endmodule

// File: rtl/twin_strike_wdg.sv
module twin_strike_wdg
  import strike_pkg::*;
#(
  parameter int CLK_HZ     = 4_000_000,
  parameter int TICK_HZ    = 1_000_000,
  parameter int ADDR_W     = 4,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              sys_rst_o
);
  localparam int PW = PERIOD_W;

  logic wr_timer, wr_ack, wr_guard;
  logic tick, expire, pending;
  logic t_en, t_per;
  logic [PW-1:0] t_period;
  logic g_en, g_sel, g_rst_en, g_sticky, g_rst;
  logic [31:0] timer_view, ack_view, guard_view;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata;

  assign wr_timer = bus_wr && (bus_addr == ADDR_W'(OFS_TIMER));
  assign wr_ack   = bus_wr && (bus_addr == ADDR_W'(OFS_ACK));
  assign wr_guard = bus_wr && (bus_addr == ADDR_W'(OFS_GUARD));

  strike_tick_gen #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_tick (
    .clk(clk), .rst(rst), .restart(wr_timer), .tick(tick)
  );

  strike_timer #(.PW(PW)) u_timer (
    .clk(clk), .rst(rst), .tick(tick),
    .ctrl_wr(wr_timer),
    .ctrl_en(bus_wdata[TMR_EN_BIT]),
    .ctrl_per(bus_wdata[TMR_PER_BIT]),
    .ctrl_period(bus_wdata[PW-1:0]),
    .ack(wr_ack && bus_wdata[ACK_BIT]),
    .en_q(t_en), .per_q(t_per), .period_q(t_period),
    .expire(expire), .pending_q(pending)
  );

  strike_guard #(.RST_CYCLES(RST_CYCLES)) u_guard (
    .clk(clk), .rst(rst), .cfg_wr(wr_guard),
    .cfg_en(bus_wdata[G_EN_BIT]),
    .cfg_sel(bus_wdata[G_SEL_BIT]),
    .cfg_rst_en(bus_wdata[G_RSTEN_BIT]),
    .expire(expire), .pending(pending),
    .en_q(g_en), .sel_q(g_sel), .rst_en_q(g_rst_en),
    .sticky_q(g_sticky), .sys_rst_q(g_rst)
  );

  always_comb begin
    timer_view              = '0;
    timer_view[PW-1:0]      = t_period;
    timer_view[TMR_EN_BIT]  = t_en;
    timer_view[TMR_PER_BIT] = t_per;
    ack_view                = '0;
    ack_view[ACK_BIT]       = pending;
    guard_view               = '0;
    guard_view[G_EN_BIT]     = g_en;
    guard_view[G_SEL_BIT]    = g_sel;
    guard_view[G_RSTEN_BIT]  = g_rst_en;
    guard_view[G_STICKY_BIT] = g_sticky;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_addr == ADDR_W'(OFS_TIMER)) bus_rdata <= timer_view;
    else if (bus_addr == ADDR_W'(OFS_ACK))   bus_rdata <= ack_view;
    else if (bus_addr == ADDR_W'(OFS_GUARD)) bus_rdata <= guard_view;
    else bus_rdata <= '0;
  end

  assign irq_o     = pending;
  assign sys_rst_o = g_rst;

  // R5: the interrupt output rises only on the edge after a timer expiry
  p_irq_from_expiry_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(expire));
endmodule

// File: tb/twin_strike_wdg_tb_top.sv
module twin_strike_wdg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int RSTC = 8;
  localparam int P = 5;
  localparam int T = P * DIV;
  localparam logic [31:0] ACKW = 32'h4000_0000;

  typedef struct {
    int    cyc;
    int    sig;
    logic  val;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_o, sys_rst_o;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  exp_t sb[$];
  exp_t it;

  twin_strike_wdg #(.CLK_HZ(4_000_000), .TICK_HZ(1_000_000), .ADDR_W(4),
                    .RST_CYCLES(RSTC)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  // monitor: pops scoreboard items due in the current cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      it = sb.pop_front();
      if (it.cyc < cyc) chk({it.req, " (missed slot)"}, 32'(it.cyc), 32'(cyc));
      else if (it.sig == 0) chk({it.req, " irq_o"}, {31'b0, irq_o}, {31'b0, it.val});
      else chk({it.req, " sys_rst_o"}, {31'b0, sys_rst_o}, {31'b0, it.val});
    end
  end

  task automatic expect_at(input int c, input int sig, input logic v, input string req);
    exp_t e;
    e.cyc = c; e.sig = sig; e.val = v; e.req = req;
    sb.push_back(e);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, output int edge_c);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    edge_c = cyc;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic upto(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic cleanup();
    int e;
    wr(4'h0, 32'h0, e);
    wr(4'h4, ACKW, e);
    upto(e + 12);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int w, w2, e;
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 rst", {31'b0, sys_rst_o}, 32'h0);
    rd(4'h0, v); chk("R1 timer reg", v, 32'h0);
    rd(4'h4, v); chk("R1 ack reg", v, 32'h0);
    rd(4'h8, v); chk("R1 guard reg", v, 32'h0);

    // R2 / R4 / R5: one-shot timer
    wr(4'h0, 32'h8000_0005, w);
    expect_at(w + T - 1, 0, 1'b0, "R2");
    expect_at(w + T, 0, 1'b1, "R2");
    upto(w + T + 2);
    rd(4'h0, v); chk("R4 enable cleared", v, 32'h0000_0005);
    rd(4'h4, v); chk("R5 pending read", v, ACKW);
    wr(4'h4, 32'h0, e);
    chk("R5 zero ack ignored", {31'b0, irq_o}, 32'h1);
    wr(4'h4, ACKW, e);
    chk("R5 ack clears", {31'b0, irq_o}, 32'h0);
    rd(4'h4, v); chk("R5 pending cleared", v, 32'h0);
    upto(e + 3 * T);
    chk("R4 no further expiry", {31'b0, irq_o}, 32'h0);

    // R3 / R10: periodic timer, no watchdog
    wr(4'h0, 32'hC000_0005, w);
    expect_at(w + T, 0, 1'b1, "R3");
    upto(w + T + 1);
    wr(4'h4, ACKW, e);
    expect_at(w + 2 * T - 1, 0, 1'b0, "R3");
    expect_at(w + 2 * T, 0, 1'b1, "R3");
    upto(w + 2 * T + 1);
    wr(4'h4, ACKW, e);
    wr(4'h0, 32'h0, e);
    upto(e + 3 * T);
    chk("R10 timer stopped", {31'b0, irq_o}, 32'h0);

    // R6 / R9: two-strike reset, fire-once and re-arm
    wr(4'h8, 32'h24, e);
    wr(4'h0, 32'hC000_0005, w);
    expect_at(w + T, 0, 1'b1, "R6");
    expect_at(w + 2 * T - 1, 1, 1'b0, "R6");
    expect_at(w + 2 * T, 1, 1'b1, "R6");
    expect_at(w + 2 * T + RSTC - 1, 1, 1'b1, "R6");
    expect_at(w + 2 * T + RSTC, 1, 1'b0, "R6");
    expect_at(w + 3 * T, 1, 1'b0, "R9");
    expect_at(w + 3 * T + 1, 1, 1'b0, "R9");
    upto(w + 3 * T + 2);
    rd(4'h8, v); chk("R6 config read", v, 32'h24);
    wr(4'h8, 32'h24, e);
    expect_at(w + 4 * T, 1, 1'b1, "R9 re-armed");
    upto(w + 4 * T + 1);
    cleanup();

    // R7: acknowledge between strikes
    wr(4'h8, 32'h24, e);
    wr(4'h0, 32'hC000_0005, w);
    expect_at(w + T, 0, 1'b1, "R7");
    upto(w + T + 5);
    wr(4'h4, ACKW, e);
    expect_at(w + 2 * T, 0, 1'b1, "R7");
    expect_at(w + 2 * T, 1, 1'b0, "R7");
    expect_at(w + 2 * T + 1, 1, 1'b0, "R7");
    upto(w + 2 * T + 5);
    cleanup();

    // R8: strike with reset enable clear
    wr(4'h8, 32'h20, e);
    wr(4'h0, 32'hC000_0005, w);
    expect_at(w + 2 * T, 1, 1'b0, "R8");
    expect_at(w + 2 * T + 1, 1, 1'b0, "R8");
    upto(w + 2 * T + 2);
    rd(4'h8, v); chk("R8 sticky set", v, 32'h120);
    cleanup();

    // R11: timer select points away
    wr(4'h8, 32'h34, e);
    wr(4'h0, 32'hC000_0005, w);
    expect_at(w + 2 * T, 1, 1'b0, "R11");
    expect_at(w + 2 * T + 1, 1, 1'b0, "R11");
    upto(w + 2 * T + 2);
    rd(4'h8, v); chk("R11 no sticky", v, 32'h34);
    cleanup();

    // R10: zero config disables watchdog
    wr(4'h8, 32'h24, e);
    wr(4'h8, 32'h0, e);
    wr(4'h0, 32'hC000_0005, w);
    expect_at(w + 2 * T, 1, 1'b0, "R10");
    expect_at(w + 2 * T + 1, 1, 1'b0, "R10");
    upto(w + 2 * T + 2);
    rd(4'h8, v); chk("R10 config zero", v, 32'h0);
    cleanup();

    // R12: rewrite while running restarts the count
    wr(4'h0, 32'h8000_0005, w);
    upto(w + 12);
    rd(4'h0, v); chk("R12 timer read", v, 32'h8000_0005);
    wr(4'h0, 32'h8000_0005, w2);
    expect_at(w + T, 0, 1'b0, "R12");
    expect_at(w2 + T - 1, 0, 1'b0, "R12");
    expect_at(w2 + T, 0, 1'b1, "R12");
    upto(w2 + T + 2);
    cleanup();

    chk("scoreboard drained", 32'(sb.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule